// File: doc/BRIEF.md
# Event Flag and Interrupt Unit

This unit sits beside one processor core and turns eight one-cycle hardware event strobes into sticky flags. Software uses the flags in three ways. It can poll a flag: the value is read and cleared in one step. It can wait on a flag, with an optional deadline. It can route a flag to one of three interrupt channels. The timer event is produced inside the unit by a reloading down-counter.

Interrupt requests pass through a deferral gate. While the gate is closed, new events are still recorded as pending on their channels. When the gate reopens they are presented in priority order, one request at a time. Each request is held until the core acknowledges it, and each acknowledge raises the interrupt-taken event.

Top module: `evt_irq_unit`

## Requirements
- R1: Each event has a sticky flag. Flag index 0 is interrupt-taken, 1 is timer, 2 is edge, 3 is transfer-rollover, 4 is block-wrap, 5 is long-read, 6 is long-write and 7 is breakpoint. A one-cycle strobe on `evt_strobe_i[k]` sets flag k, and the flag stays set until an operation clears it.
- R2: Command op 1 (get), when accepted, returns flag `cmd_sel_i` on `carry_o` one cycle later, pulses `done_o`, and clears that flag.
- R3: If a flag receives a set and a clear in the same cycle, the flag ends up set.
- R4: Command op 2 (wait) raises `busy_o` until flag `cmd_sel_i` is set. It then drops `busy_o`, pulses `done_o` with `carry_o`=0 and clears the flag. A flag that is already set ends the wait one cycle after the command.
- R5: Command op 3 (wait with deadline) behaves like op 2. It also ends with `carry_o`=1 once the signed difference `now_i - cmd_data_i` is zero or positive, so the deadline works across counter wrap. A plain wait never ends with `carry_o`=1.
- R6: Command op 4 writes mode `cmd_data_i[2:0]` into channel `cmd_sel_i` (0..2). Mode 0 means off, and every channel is off after reset. Mode k (1..7) makes the channel fire on event k.
- R7: Command op 6 closes the interrupt gate and op 7 opens it. The gate is open after reset. Events that arrive while the gate is closed stay pending and are requested once it opens.
- R8: Only one request is presented at a time, on `irq_req_o` and `irq_chan_o`. The lowest-numbered pending channel wins. The request and its channel stay unchanged until `irq_ack_i`. The acknowledge clears that channel's pending state and sets flag 0.
- R9: Command op 5 loads timer period P from `cmd_data_i`. With P > 0, flag 1 is set every P cycles, and a wait on flag 1 issued one cycle after the load completes 10 cycles after it is issued when P=10. P=0 stops the timer.
- R10: Commands presented while `busy_o` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_strobe_i | input | 8 | One-cycle event strobes, one per flag index |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | 0 nop, 1 get, 2 wait, 3 wait with deadline, 4 set mode, 5 set period, 6 close gate, 7 open gate |
| cmd_sel_i | input | 3 | Flag select, or channel number for set mode |
| cmd_data_i | input | 32 | Mode value, timer period or deadline |
| now_i | input | 32 | Free-running time counter |
| carry_o | output | 1 | Result bit of the last get or wait |
| busy_o | output | 1 | A wait is in progress |
| done_o | output | 1 | One-cycle pulse when a get or wait completes |
| irq_req_o | output | 1 | Interrupt request |
| irq_chan_o | output | 2 | Channel of the presented request |
| irq_ack_i | input | 1 | Acknowledge of the presented request |

## Verification
Polling is driven with a table of strobe masks:
- single bits, several bits at once, and reads of a neighbouring clear flag, which show that the select picks exactly one flag;
- a set that lands in the same cycle as the clear, which separates "set wins" from "clear wins".

Waits are measured in cycles:
- a deadline placed just past a counter wrap tells a signed comparison apart from an unsigned one;
- the timer test fixes the period count exactly, off-by-one included.

Interrupts are tried with two channels pending under a closed gate, which shows the priority order and that deferral keeps events rather than dropping them. A strobe on an unmapped event shows that a channel left off stays silent.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int NUM_EVT   = 8;
    localparam int EVT_W     = $clog2(NUM_EVT);
    localparam int MODE_W    = 3;
    localparam int EVT_TAKEN = 0;
    localparam int EVT_TIMER = 1;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_GET     = 3'd1,
        OP_WAIT    = 3'd2,
        OP_WAITDL  = 3'd3,
        OP_SETMODE = 3'd4,
        OP_SETPER  = 3'd5,
        OP_GATE    = 3'd6,
        OP_UNGATE  = 3'd7
    } op_e;
endpackage

// File: rtl/evt_timer.sv
module evt_timer #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] per_i,
    output logic          tick_o
);
    typedef struct packed {
        logic [TW-1:0] per;
        logic [TW-1:0] cnt;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        tick_o = 1'b0;
        if (load_i) begin
            st_d.per = per_i;
            st_d.cnt = per_i;
        end else if (st_q.per != '0) begin
            if (st_q.cnt <= TW'(1)) begin
                tick_o   = 1'b1;
                st_d.cnt = st_q.per;
            end else begin
                st_d.cnt = st_q.cnt - TW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TMR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.per != '0) |-> (st_q.cnt != '0 && st_q.cnt <= st_q.per)); // R9
endmodule

// File: rtl/evt_flags.sv
module evt_flags #(
    parameter int NEVT = 8,
    parameter int SW   = $clog2(NEVT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEVT-1:0] hit_i,
    input  logic            clr_i,
    input  logic [SW-1:0]   sel_i,
    output logic            sel_val_o
);
    typedef struct packed {
        logic [NEVT-1:0] flag;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NEVT; i++) begin
            if (clr_i && sel_i == SW'(i)) st_d.flag[i] = 1'b0;
            if (hit_i[i])                 st_d.flag[i] = 1'b1;
        end
    end

    assign sel_val_o = st_q.flag[sel_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i != '0) |=> ((st_q.flag & $past(hit_i)) == $past(hit_i))); // R3

    for (genvar g = 0; g < NEVT; g++) begin : g_hold
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.flag[g] && !(clr_i && sel_i == SW'(g))) |=> st_q.flag[g]); // R1
    end
endmodule

// File: rtl/evt_irq.sv
module evt_irq #(
    parameter int NCH  = 3,
    parameter int CHW  = $clog2(NCH),
    parameter int NEVT = 8,
    parameter int MW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEVT-1:0] hit_i,
    input  logic            mode_we_i,
    input  logic [CHW-1:0]  mode_ch_i,
    input  logic [MW-1:0]   mode_val_i,
    input  logic            gate_i,
    input  logic            ungate_i,
    input  logic            ack_i,
    output logic            req_o,
    output logic [CHW-1:0]  chan_o,
    output logic            taken_o
);
    typedef struct packed {
        logic [NCH-1:0][MW-1:0] mode;
        logic [NCH-1:0]         pend;
        logic                   open;
        logic                   req;
        logic [CHW-1:0]         chan;
    } st_t;

    st_t  st_q, st_d;
    logic ack_fire;

    assign ack_fire = st_q.req && ack_i;

    always_comb begin
        st_d = st_q;
        if (ack_fire) begin
            st_d.pend[st_q.chan] = 1'b0;
            st_d.req             = 1'b0;
        end
        for (int c = 0; c < NCH; c++) begin
            if (st_q.mode[c] != '0 && hit_i[st_q.mode[c]]) st_d.pend[c] = 1'b1;
        end
        if (mode_we_i) begin
            st_d.mode[mode_ch_i] = mode_val_i;
            st_d.pend[mode_ch_i] = 1'b0;
        end
        if (gate_i)   st_d.open = 1'b0;
        if (ungate_i) st_d.open = 1'b1;
        if (!st_q.req && st_q.open && st_q.pend != '0) begin
            st_d.req = 1'b1;
            for (int c = NCH - 1; c >= 0; c--) begin
                if (st_q.pend[c]) st_d.chan = CHW'(c);
            end
        end
    end

    assign req_o   = st_q.req;
    assign chan_o  = st_q.chan;
    assign taken_o = ack_fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.open <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req && !ack_i) |=> (st_q.req && $stable(st_q.chan))); // R8
    AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.req) |-> $past(st_q.open)); // R7

    for (genvar g = 0; g < NCH; g++) begin : g_off
        AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.mode[g] == '0) |-> !st_q.pend[g]); // R6
    end
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
    import evt_pkg::*;
#(
    parameter int TW  = 32,
    parameter int NCH = 3,
    parameter int CHW = $clog2(NCH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_strobe_i,
    input  logic               cmd_valid_i,
    input  logic [2:0]         cmd_op_i,
    input  logic [EVT_W-1:0]   cmd_sel_i,
    input  logic [TW-1:0]      cmd_data_i,
    input  logic [TW-1:0]      now_i,
    output logic               carry_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               irq_req_o,
    output logic [CHW-1:0]     irq_chan_o,
    input  logic               irq_ack_i
);
    typedef struct packed {
        logic             busy;
        logic             use_dl;
        logic [EVT_W-1:0] sel;
        logic [TW-1:0]    target;
        logic             carry;
        logic             done;
    } st_t;

    st_t                st_q, st_d;
    op_e                op;
    logic               accept;
    logic               tick;
    logic               taken;
    logic [NUM_EVT-1:0] hit;
    logic [EVT_W-1:0]   mux_sel;
    logic               mux_val;
    logic               clr_en;
    logic [TW-1:0]      dl_diff;
    logic               mode_we;

    assign op      = op_e'(cmd_op_i);
    assign accept  = cmd_valid_i && !st_q.busy;
    assign mux_sel = st_q.busy ? st_q.sel : cmd_sel_i;
    assign dl_diff = now_i - st_q.target;
    assign mode_we = accept && op == OP_SETMODE && cmd_sel_i < EVT_W'(NCH);

    always_comb begin
        hit            = evt_strobe_i;
        hit[EVT_TIMER] = evt_strobe_i[EVT_TIMER] | tick;
        hit[EVT_TAKEN] = evt_strobe_i[EVT_TAKEN] | taken;
    end

    evt_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept && op == OP_SETPER),
        .per_i  (cmd_data_i),
        .tick_o (tick)
    );

    evt_flags #(.NEVT(NUM_EVT), .SW(EVT_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hit),
        .clr_i     (clr_en),
        .sel_i     (mux_sel),
        .sel_val_o (mux_val)
    );

    evt_irq #(.NCH(NCH), .CHW(CHW), .NEVT(NUM_EVT), .MW(MODE_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit),
        .mode_we_i  (mode_we),
        .mode_ch_i  (cmd_sel_i[CHW-1:0]),
        .mode_val_i (cmd_data_i[MODE_W-1:0]),
        .gate_i     (accept && op == OP_GATE),
        .ungate_i   (accept && op == OP_UNGATE),
        .ack_i      (irq_ack_i),
        .req_o      (irq_req_o),
        .chan_o     (irq_chan_o),
        .taken_o    (taken)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        clr_en    = 1'b0;
        if (st_q.busy) begin
            if (mux_val) begin
                clr_en     = 1'b1;
                st_d.carry = 1'b0;
                st_d.done  = 1'b1;
                st_d.busy  = 1'b0;
            end else if (st_q.use_dl && !dl_diff[TW-1]) begin
                st_d.carry = 1'b1;
                st_d.done  = 1'b1;
                st_d.busy  = 1'b0;
            end
        end else if (accept) begin
            case (op)
                OP_GET: begin
                    clr_en     = 1'b1;
                    st_d.carry = mux_val;
                    st_d.done  = 1'b1;
                end
                OP_WAIT, OP_WAITDL: begin
                    st_d.busy   = 1'b1;
                    st_d.use_dl = (op == OP_WAITDL);
                    st_d.sel    = cmd_sel_i;
                    st_d.target = cmd_data_i;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign carry_o = st_q.carry;
    assign busy_o  = st_q.busy;
    assign done_o  = st_q.done;

    AST_GET_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && !busy_o && cmd_op_i == 3'd1) |=> done_o); // R2
    AST_PLAIN_WAIT_NO_DL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.busy) && !$past(st_q.use_dl)) |-> !carry_o); // R5
    AST_WAIT_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> done_o); // R4
endmodule

// File: tb/tb_evt_irq_unit.sv
`timescale 1ns/1ps
module tb_evt_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  strobe = '0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [2:0]  cmd_sel = '0;
    logic [31:0] cmd_data = '0;
    logic [31:0] now_r = '0;
    logic        now_ld = 1'b0;
    logic [31:0] now_val = '0;
    logic        carry, busy, done, irq_req, irq_ack = 1'b0;
    logic [1:0]  irq_chan;
    int          checks = 0;
    int          errors = 0;
    int          n;

    always #10 clk = ~clk;

    always @(posedge clk) now_r <= now_ld ? now_val : now_r + 32'd1;

    evt_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .evt_strobe_i(strobe),
        .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_sel_i(cmd_sel),
        .cmd_data_i(cmd_data), .now_i(now_r), .carry_o(carry),
        .busy_o(busy), .done_o(done), .irq_req_o(irq_req),
        .irq_chan_o(irq_chan), .irq_ack_i(irq_ack)
    );

    // {strobe mask, select, expected carry}
    localparam logic [11:0] VEC [0:5] = '{
        {8'h04, 3'd2, 1'b1},
        {8'h04, 3'd3, 1'b0},
        {8'hA0, 3'd7, 1'b1},
        {8'hA0, 3'd6, 1'b0},
        {8'h81, 3'd0, 1'b1},
        {8'h7E, 3'd1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [2:0] sel, input logic [31:0] data);
        cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] m);
        strobe = m;
        @(negedge clk);
        strobe = '0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic clear_all();
        for (int s = 0; s < 8; s++) do_cmd(3'd1, 3'(s), 32'd0);
    endtask

    task automatic set_now(input logic [31:0] v);
        now_ld = 1'b1; now_val = v;
        @(negedge clk);
        now_ld = 1'b0;
    endtask

    task automatic count_busy();
        n = 0;
        while (busy && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset no request", irq_req, 0);
        check("R4 reset not busy", busy, 0);
        check("R2 reset no done", done, 0);

        // R1 R2: table of strobe patterns and polls
        for (int i = 0; i < 6; i++) begin
            pulse(VEC[i][11:4]);
            do_cmd(3'd1, VEC[i][3:1], 32'd0);
            check("R2 get value", carry, VEC[i][0]);
            check("R2 done pulse", done, 1);
            clear_all();
        end

        // R1 sticky, R2 clear
        pulse(8'h08);
        repeat (5) @(negedge clk);
        do_cmd(3'd1, 3'd3, 0);
        check("R1 sticky", carry, 1);
        do_cmd(3'd1, 3'd3, 0);
        check("R2 cleared", carry, 0);

        // R3 set and clear in same cycle
        strobe = 8'h10;
        do_cmd(3'd1, 3'd4, 0);
        strobe = '0;
        check("R3 get", carry, 0);
        do_cmd(3'd1, 3'd4, 0);
        check("R3 set wins", carry, 1);
        do_cmd(3'd1, 3'd4, 0);
        check("R3 then clear", carry, 0);

        // R4 wait
        do_cmd(3'd2, 3'd2, 0);
        check("R4 busy", busy, 1);
        repeat (3) @(negedge clk);
        check("R4 still busy", busy, 1);
        pulse(8'h04);
        check("R4 busy until flag", busy, 1);
        @(negedge clk);
        check("R4 released", busy, 0);
        check("R4 done", done, 1);
        check("R4 carry", carry, 0);
        do_cmd(3'd1, 3'd2, 0);
        check("R4 flag cleared", carry, 0);
        pulse(8'h20);
        do_cmd(3'd2, 3'd5, 0);
        @(negedge clk);
        check("R4 preset flag ends", busy, 0);

        // R5 deadline
        set_now(32'd1000);
        do_cmd(3'd3, 3'd6, now_r + 32'd6);
        count_busy();
        check("R5 deadline cycles", n, 6);
        check("R5 deadline carry", carry, 1);
        set_now(32'hFFFF_FFF0);
        do_cmd(3'd3, 3'd6, 32'h0000_0004);
        count_busy();
        check("R5 wrap cycles", n, 20);
        check("R5 wrap carry", carry, 1);

        // R10 command ignored while busy
        do_cmd(3'd2, 3'd6, 0);
        do_cmd(3'd5, 3'd0, 32'd3);
        pulse(8'h40);
        @(negedge clk);
        check("R10 wait done", busy, 0);
        repeat (10) @(negedge clk);
        do_cmd(3'd1, 3'd1, 0);
        check("R10 period ignored", carry, 0);

        // R9 timer
        do_cmd(3'd5, 3'd0, 32'd10);
        do_cmd(3'd2, 3'd1, 0);
        count_busy();
        check("R9 period cycles", n, 10);
        check("R9 carry", carry, 0);
        do_cmd(3'd5, 3'd0, 32'd0);
        do_cmd(3'd1, 3'd1, 0);
        repeat (25) @(negedge clk);
        do_cmd(3'd1, 3'd1, 0);
        check("R9 stopped", carry, 0);
        clear_all();

        // R6 R7 R8 interrupts
        do_cmd(3'd4, 3'd0, 32'd5);
        do_cmd(3'd4, 3'd1, 32'd2);
        do_cmd(3'd6, 3'd0, 0);
        pulse(8'h24);
        repeat (4) @(negedge clk);
        check("R7 deferred", irq_req, 0);
        do_cmd(3'd7, 3'd0, 0);
        @(negedge clk);
        check("R7 after open", irq_req, 1);
        check("R8 priority", irq_chan, 0);
        repeat (3) @(negedge clk);
        check("R8 held req", irq_req, 1);
        check("R8 held chan", irq_chan, 0);
        ack();
        check("R8 ack drops", irq_req, 0);
        @(negedge clk);
        check("R8 next req", irq_req, 1);
        check("R8 next chan", irq_chan, 1);
        ack();
        do_cmd(3'd1, 3'd0, 0);
        check("R8 taken flag", carry, 1);
        do_cmd(3'd1, 3'd2, 0);
        check("R1 edge flag also set", carry, 1);
        pulse(8'h80);
        repeat (3) @(negedge clk);
        check("R6 off channel silent", irq_req, 0);
        do_cmd(3'd4, 3'd2, 32'd7);
        pulse(8'h80);
        @(negedge clk);
        check("R6 mode 7 req", irq_req, 1);
        check("R6 mode 7 chan", irq_chan, 2);
        ack();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule